// File: doc/BRIEF.md
# Dual Programmable Clock-Enable Divider

This block takes one fast reference clock and produces two periodic clock enables from it. The core-rate enable divides the reference by 1, 2, 4 or 8, chosen by a 2-bit logarithmic code. The system-rate enable divides it by any integer from 1 to 15, chosen by a 4-bit linear field. Both outputs are one-cycle pulses that are synchronous to the reference clock. Downstream logic uses them as clock enables.

A single write strobe loads both ratio fields and a mirror-enable bit. A ratio can be changed while the block is running, with no stall and no settling time. Each divider adopts its new ratio at the end of the period it is currently counting, so no period is ever shortened. If a write carries a system ratio of zero, that field is rejected and an error flag is raised. The active ratios can be read back at all times.

A mirror output reproduces the system-rate waveform for use off chip. It is controlled by a four-state machine:
- `MIR_OFF`: the output is held low.
- `MIR_ARMED`: the enable bit is set and the machine waits for a system-period boundary.
- `MIR_RUN`: the output follows the system-period waveform.
- `MIR_DRAIN`: the enable bit has been cleared and the current period is being finished.

The transitions are:
- T_ARM: `MIR_OFF` to `MIR_ARMED`, when the bit is set.
- T_ABORT: `MIR_ARMED` to `MIR_OFF`, when the bit is cleared.
- T_START: `MIR_ARMED` to `MIR_RUN`, on a system pulse.
- T_STOP: `MIR_RUN` to `MIR_DRAIN`, when the bit is cleared.
- T_RESUME: `MIR_DRAIN` to `MIR_RUN`, when the bit is set again.
- T_DONE: `MIR_DRAIN` to `MIR_OFF`, on a system pulse.

Top module: `dual_clkdiv_top`

## Requirements
- R1: Reset values are as follows: system ratio 4, core code 00 (ratio 1), `cfg_err` low and `mirror_clk` low. In the first cycle after reset is released, both `sys_en` and `core_en` are high.
- R2: With an active system ratio N (1..15), `sys_en` is high for one reference cycle in every N; with N = 1 it is high in every cycle.
- R3: The core code maps to ratios as 00 = 1, 01 = 2, 10 = 4 and 11 = 8. `core_en` is high for one cycle in every ratio cycles.
- R4: A write with `wr_sys_ratio` = 0 leaves the system ratio unchanged and sets `cfg_err` in the following cycle. The core code in the same write is still applied. A later write with a nonzero system field clears `cfg_err`.
- R5: A written ratio is adopted at the next period boundary of its divider. Every pulse-to-pulse gap is either the old ratio or the new one, and once a new-ratio gap has occurred no old-ratio gap follows. A readback value changes only in the cycle right after a pulse of its divider.
- R6: `rd_sys_ratio` and `rd_core_code` report the ratios currently being counted. Once a write has settled, they equal the written values.
- R7: While the mirror-enable bit is clear, and after reset, `mirror_clk` is low.
- R8: After the bit is set, `mirror_clk` stays low through the first `sys_en` pulse seen after the write cycle. From the next cycle it is high for the first ceil(N/2) cycles of each system period and low for the rest. With N = 1 it is steadily high.
- R9: After the bit is cleared, `mirror_clk` keeps its waveform up to and including the next `sys_en` pulse seen after the write cycle, and is low from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| wr_stb | input | 1 | Write strobe that loads all three fields |
| wr_core_code | input | 2 | Core ratio code (log2 of the ratio) |
| wr_sys_ratio | input | 4 | System ratio, 1..15 (0 is rejected) |
| wr_mirror_en | input | 1 | Mirror output enable |
| core_en | output | 1 | Core-rate clock enable |
| sys_en | output | 1 | System-rate clock enable |
| mirror_clk | output | 1 | Gated mirror of the system-rate clock |
| cfg_err | output | 1 | The last write carried an illegal system ratio |
| rd_core_code | output | 2 | Active core code |
| rd_sys_ratio | output | 4 | Active system ratio |

## Verification
The divider is exercised with every pairing of the four core codes and the fifteen legal system ratios. Each setting is allowed to settle, and then the pulse-to-pulse gaps and the readback are measured; this distinguishes an off-by-one counter load, a wrong code-to-ratio mapping, and readback that is not tied to the active ratio. Two live changes are applied, one to a larger ratio and one to a smaller ratio. Their gap sequences and readback timing show whether a ratio is adopted mid-period or only at a boundary. The mirror is enabled and disabled at a known phase and compared cycle by cycle against the computed waveform, and a ratio-1 run and a zero-ratio write cover the corner cases.

// File: rtl/dual_clkdiv_pkg.sv
package dual_clkdiv_pkg;

    typedef enum logic [1:0] {
        MIR_OFF   = 2'd0,
        MIR_ARMED = 2'd1,
        MIR_RUN   = 2'd2,
        MIR_DRAIN = 2'd3
    } mir_state_t;

    // Position of the highest set bit; for a power of two this is its log2.
    function automatic int unsigned msb_index(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/dual_clkdiv_cfg.sv
module dual_clkdiv_cfg #(
    parameter int SYS_W    = 4,
    parameter int CODE_W   = 2,
    parameter int SYS_RST  = 4,
    parameter int CODE_RST = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [SYS_W-1:0]  wr_sys,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_mir,
    output logic [SYS_W-1:0]  pend_sys,
    output logic [CODE_W-1:0] pend_code,
    output logic              mir_on,
    output logic              cfg_err
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_sys  <= SYS_W'(SYS_RST);
            pend_code <= CODE_W'(CODE_RST);
            mir_on    <= 1'b0;
            cfg_err   <= 1'b0;
        end else if (wr_stb) begin
            pend_code <= wr_code;
            mir_on    <= wr_mir;
            if (wr_sys == '0) begin
                cfg_err <= 1'b1;
            end else begin
                pend_sys <= wr_sys;
                cfg_err  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dual_clkdiv_rate.sv
module dual_clkdiv_rate #(
    parameter int RATIO_W   = 4,
    parameter int RST_RATIO = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] next_ratio,
    output logic               tick,
    output logic               hi_phase,
    output logic [RATIO_W-1:0] active_ratio
);

    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] act_q;

    // A period ends when the down-counter reaches zero; the next ratio is
    // sampled only there, so a period in progress is never cut short.
    assign tick         = (cnt_q == '0);
    assign hi_phase     = (cnt_q >= (act_q >> 1));
    assign active_ratio = act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= RATIO_W'(RST_RATIO);
        end else if (tick) begin
            cnt_q <= next_ratio - RATIO_W'(1);
            act_q <= next_ratio;
        end else begin
            cnt_q <= cnt_q - RATIO_W'(1);
        end
    end

endmodule

// File: rtl/dual_clkdiv_mirror.sv
module dual_clkdiv_mirror
    import dual_clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mir_on,
    input  logic sys_tick,
    input  logic hi_phase,
    output logic mirror_clk
);

    mir_state_t state_q;
    mir_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MIR_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MIR_OFF:   if (mir_on) state_d = MIR_ARMED;            // T_ARM
            MIR_ARMED: if (!mir_on) state_d = MIR_OFF;             // T_ABORT
                       else if (sys_tick) state_d = MIR_RUN;       // T_START
            MIR_RUN:   if (!mir_on) state_d = MIR_DRAIN;           // T_STOP
            MIR_DRAIN: if (mir_on) state_d = MIR_RUN;              // T_RESUME
                       else if (sys_tick) state_d = MIR_OFF;       // T_DONE
            default:   state_d = MIR_OFF;
        endcase
    end

    always_comb begin
        unique case (state_q)
            MIR_RUN, MIR_DRAIN: mirror_clk = hi_phase;
            default:            mirror_clk = 1'b0;
        endcase
    end

endmodule

// File: rtl/dual_clkdiv_top.sv
module dual_clkdiv_top
    import dual_clkdiv_pkg::*;
#(
    parameter int SYS_W    = 4,
    parameter int CODE_W   = 2,
    parameter int SYS_RST  = 4,
    parameter int CODE_RST = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [CODE_W-1:0] wr_core_code,
    input  logic [SYS_W-1:0]  wr_sys_ratio,
    input  logic              wr_mirror_en,
    output logic              core_en,
    output logic              sys_en,
    output logic              mirror_clk,
    output logic              cfg_err,
    output logic [CODE_W-1:0] rd_core_code,
    output logic [SYS_W-1:0]  rd_sys_ratio
);

    localparam int CORE_RW  = 2 ** CODE_W;
    localparam int CORE_RST = 2 ** CODE_RST;

    logic [SYS_W-1:0]   pend_sys;
    logic [CODE_W-1:0]  pend_code;
    logic               mir_on;
    logic [CORE_RW-1:0] core_next;
    logic [CORE_RW-1:0] core_act;
    logic               core_hi;
    logic               sys_hi;

    dual_clkdiv_cfg #(
        .SYS_W(SYS_W), .CODE_W(CODE_W), .SYS_RST(SYS_RST), .CODE_RST(CODE_RST)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
        .wr_sys(wr_sys_ratio), .wr_code(wr_core_code), .wr_mir(wr_mirror_en),
        .pend_sys(pend_sys), .pend_code(pend_code), .mir_on(mir_on), .cfg_err(cfg_err)
    );

    assign core_next = CORE_RW'(1) << pend_code;

    dual_clkdiv_rate #(.RATIO_W(CORE_RW), .RST_RATIO(CORE_RST)) core_div_i (
        .clk(clk), .rst_n(rst_n), .next_ratio(core_next),
        .tick(core_en), .hi_phase(core_hi), .active_ratio(core_act)
    );

    dual_clkdiv_rate #(.RATIO_W(SYS_W), .RST_RATIO(SYS_RST)) sys_div_i (
        .clk(clk), .rst_n(rst_n), .next_ratio(pend_sys),
        .tick(sys_en), .hi_phase(sys_hi), .active_ratio(rd_sys_ratio)
    );

    assign rd_core_code = CODE_W'(msb_index(32'(core_act)));

    dual_clkdiv_mirror mirror_i (
        .clk(clk), .rst_n(rst_n), .mir_on(mir_on),
        .sys_tick(sys_en), .hi_phase(sys_hi), .mirror_clk(mirror_clk)
    );

    logic unused_core_hi;
    assign unused_core_hi = core_hi;

endmodule

// File: rtl/dual_clkdiv_chk.sv
module dual_clkdiv_chk #(
    parameter int SYS_W  = 4,
    parameter int CODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [SYS_W-1:0]  wr_sys_ratio,
    input logic              core_en,
    input logic              sys_en,
    input logic              mirror_clk,
    input logic              cfg_err,
    input logic [CODE_W-1:0] rd_core_code,
    input logic [SYS_W-1:0]  rd_sys_ratio
);

    AST_ERR_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sys_ratio == '0) |=> cfg_err); // R4
    AST_RATIO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sys_ratio != '0); // R4
    AST_SYS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        sys_en |=> (rd_sys_ratio == SYS_W'(1) || !sys_en)); // R2
    AST_CORE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |=> (rd_core_code == '0 || !core_en)); // R3
    AST_SYS_SWITCH_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_sys_ratio) |-> $past(sys_en)); // R5
    AST_CORE_SWITCH_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_core_code) |-> $past(core_en)); // R5
    AST_MIRROR_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mirror_clk) |-> $past(sys_en)); // R8

endmodule

bind dual_clkdiv_top dual_clkdiv_chk #(.SYS_W(SYS_W), .CODE_W(CODE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sys_ratio(wr_sys_ratio),
    .core_en(core_en), .sys_en(sys_en), .mirror_clk(mirror_clk), .cfg_err(cfg_err),
    .rd_core_code(rd_core_code), .rd_sys_ratio(rd_sys_ratio)
);

// File: tb/dual_clkdiv_top_tb_top.sv
`timescale 1ns/1ps
module dual_clkdiv_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [1:0] wr_core_code = '0;
    logic [3:0] wr_sys_ratio = '0;
    logic       wr_mirror_en = 1'b0;
    logic       core_en, sys_en, mirror_clk, cfg_err;
    logic [1:0] rd_core_code;
    logic [3:0] rd_sys_ratio;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dual_clkdiv_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_core_code(wr_core_code),
        .wr_sys_ratio(wr_sys_ratio), .wr_mirror_en(wr_mirror_en),
        .core_en(core_en), .sys_en(sys_en), .mirror_clk(mirror_clk), .cfg_err(cfg_err),
        .rd_core_code(rd_core_code), .rd_sys_ratio(rd_sys_ratio)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int core, input int sys, input bit mir);
        wr_stb = 1'b1;
        wr_core_code = core[1:0];
        wr_sys_ratio = sys[3:0];
        wr_mirror_en = mir;
        step();
        wr_stb = 1'b0;
    endtask

    function automatic bit sig(input bit which);
        return which ? sys_en : core_en;
    endfunction

    // Pulse-to-pulse distance of the selected enable.
    task automatic gap(input bit which, output int g);
        int k;
        k = 0;
        while (!sig(which) && k < 64) begin
            step();
            k++;
        end
        g = 0;
        do begin
            step();
            g++;
        end while (!sig(which) && g < 64);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (R2) actual=150000 cycles expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int g;
        int highs;
        int p;
        int ex;
        bit done;
        bit seen_new;
        int switches;
        int prev_rd;
        bit prev_en;

        // R1: reset state
        repeat (3) step();
        rst_n = 1'b1;
        chk("R1 sys_en first cycle", sys_en, 1);
        chk("R1 core_en first cycle", core_en, 1);
        chk("R1 rd_sys_ratio", rd_sys_ratio, 4);
        chk("R1 rd_core_code", rd_core_code, 0);
        chk("R1 cfg_err", cfg_err, 0);
        chk("R1 mirror_clk", mirror_clk, 0);
        gap(1, g);
        chk("R1 default sys period", g, 4);
        gap(0, g);
        chk("R1 default core period", g, 1);
        highs = 0;
        for (int i = 0; i < 30; i++) begin
            if (mirror_clk) highs++;
            step();
        end
        chk("R7 mirror low while disabled", highs, 0);

        // R2 R3 R6: full sweep of codes and ratios
        for (int c = 0; c < 4; c++) begin
            for (int s = 1; s < 16; s++) begin
                wr(c, s, 1'b0);
                repeat (40) step();
                chk("R6 sys readback", rd_sys_ratio, s);
                chk("R6 core readback", rd_core_code, c);
                repeat (3) begin
                    gap(1, g);
                    chk("R2 sys period", g, s);
                end
                repeat (3) begin
                    gap(0, g);
                    chk("R3 core period", g, 1 << c);
                end
            end
        end

        // R4: zero system field
        wr(0, 7, 1'b0);
        repeat (40) step();
        wr(2, 0, 1'b0);
        chk("R4 cfg_err set", cfg_err, 1);
        repeat (40) step();
        chk("R4 sys ratio kept", rd_sys_ratio, 7);
        chk("R4 core code applied", rd_core_code, 2);
        gap(1, g);
        chk("R4 sys period kept", g, 7);
        wr(2, 9, 1'b0);
        chk("R4 cfg_err cleared", cfg_err, 0);

        // R5: live change to a larger ratio
        wr(0, 3, 1'b0);
        repeat (40) step();
        wr(0, 11, 1'b0);
        seen_new = 1'b0;
        for (int i = 0; i < 5; i++) begin
            gap(1, g);
            if (seen_new) chk("R5 no old gap after new", g, 11);
            else if (g != 11) chk("R5 gap is old ratio", g, 3);
            if (g == 11) seen_new = 1'b1;
        end
        chk("R5 new ratio reached", g, 11);

        // R5: live change to a smaller ratio, readback timing
        wr(0, 2, 1'b0);
        prev_rd = rd_sys_ratio;
        prev_en = sys_en;
        switches = 0;
        for (int i = 0; i < 30; i++) begin
            step();
            if (rd_sys_ratio != prev_rd) begin
                switches++;
                chk("R5 readback switch after pulse", prev_en, 1);
            end
            prev_rd = rd_sys_ratio;
            prev_en = sys_en;
        end
        chk("R5 readback switched once", switches, 1);
        chk("R5 readback final", rd_sys_ratio, 2);

        // R8: enable mirror with N = 5
        wr(0, 5, 1'b0);
        repeat (30) step();
        wr(0, 5, 1'b1);
        p = -1;
        for (int c = 0; c < 40; c++) begin
            ex = (p >= 0 && p < 3) ? 1 : 0;
            chk("R8 mirror waveform N=5", mirror_clk, ex);
            if (p >= 0) p = sys_en ? 0 : p + 1;
            else if (sys_en && c >= 1) p = 0;
            step();
        end

        // R8: ratio 1 gives a steady high mirror
        wr(0, 1, 1'b1);
        repeat (20) step();
        highs = 0;
        for (int i = 0; i < 10; i++) begin
            if (mirror_clk) highs++;
            step();
        end
        chk("R8 mirror steady high at N=1", highs, 10);

        // R9: disable mirror with N = 6 at a known phase
        wr(0, 6, 1'b1);
        repeat (30) step();
        while (!sys_en) step();
        for (int i = 0; i < 3; i++) begin
            step();
            p = i;
        end
        wr(0, 6, 1'b0);
        p = 3;
        done = 1'b0;
        for (int c = 0; c < 30; c++) begin
            ex = (!done && p < 3) ? 1 : 0;
            chk("R9 mirror drain", mirror_clk, ex);
            if (sys_en && c >= 1) done = 1'b1;
            p = sys_en ? 0 : p + 1;
            step();
        end
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            if (mirror_clk) highs++;
            step();
        end
        chk("R7 mirror low after disable", highs, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule